// File: doc/BRIEF.md
# UART Register File and Interrupt Prioritizer

This block is the software-facing side of a simple serial port with no FIFO. It exposes eight 32-bit registers on a word-aligned bus that carries full-word accesses only. It holds a single received byte and keeps line and modem status. From that state it derives one level interrupt and a three-bit identification code. Bit timing, baud generation and pin sampling live elsewhere. Bytes arrive on a strobe with data and per-byte error flags. Transmit bytes leave on a one-cycle strobe. The modem status byte comes in already sampled. The divisor, line-control and modem-control values are stored and driven out to the serializer.

Software writes the data word to send a byte and reads it to take the held byte. The register index is the byte address divided by four, and the window covers indices 0 to 7. Every result is registered, so read data, the error pulse, the transmit strobe and the interrupt all appear one clock after the cycle that caused them.

Top module: `uart_regfile`

## Requirements
- R1: After a synchronous reset the line-status word reads 0x60 (holding-empty bit 5 and transmitter-empty bit 6 set, everything else clear). The identification word reads 0x1, irq is low, the modem-status word reads the sampled input, and the exported control values are zero.
- R2: Register indices are fixed. 0 is data, 1 is interrupt enable, 2 is identification, 3 is line control, 4 is modem control, 5 is line status, 6 is modem status and 7 is divisor. Byte address bits [4:2] select the index and bits [1:0] are ignored. Read data is valid in the cycle after the read strobe and is zero when no read is made.
- R3: The interrupt sources are checked in a fixed order, and the first active one sets the code and drives irq high. Line errors (status bits 1 to 4) with enable bit 2 give code 0x6. Data ready with enable bit 0 gives 0x4. Holding-empty with enable bit 1 gives 0x2. Any of modem-status bits 0 to 3 with enable bit 3 gives 0x0.
- R4: When no source is both active and enabled, irq is low and the identification word reads 0x1.
- R5: Reading the data word returns the held byte and clears data ready (status bit 0).
- R6: A received byte always replaces the held byte and sets data ready. If data ready was already set and is not being consumed in that same cycle, overrun (bit 1) is set. Overrun stays set until reset. A receive in the same cycle as a data read causes no overrun.
- R7: A data write pulses tx_valid for one cycle, in the next cycle, with the write data's low 8 bits on tx_data. The held receive byte does not change.
- R8: Writes to the enable, line-control, modem-control and divisor words store all 32 bits. The last three appear on their outputs one cycle later. Only enable bits [3:0] affect the interrupt. Reads of these four words return zero.
- R9: Writes to the identification, line-status and modem-status words change no state.
- R10: bus_err pulses high in the cycle after a bad access, and read data is zero in that cycle. A bad access is any index of 8 or above, a read of a write-only word, or a write to a read-only word.
- R11: rx_ready is high exactly when data ready is clear.
- R12: irq and the identification code change at the same clock edge as the state that drives them. A read of the identification word in the cycle of a change therefore returns the code from before it.
- R13: Line-status bits 2, 3 and 4 load from rx_err[0] (parity), rx_err[1] (framing) and rx_err[2] (break) with each received byte and hold until the next one. The modem-status word is the modem_status input registered every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Registered read data |
| bus_err | output | 1 | One-cycle error pulse for a bad access |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | BYTE_W | Received byte |
| rx_err | input | 3 | Per-byte flags: parity, framing, break |
| rx_ready | output | 1 | Ready to accept a byte (data ready clear) |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | BYTE_W | Transmit byte |
| modem_status | input | 8 | Sampled modem status byte |
| lctl_o | output | REG_W | Stored line-control value |
| mctl_o | output | REG_W | Stored modem-control value |
| div_o | output | REG_W | Stored divisor value |
| irq | output | 1 | Level interrupt request |

## Verification
Each bus access is applied for one cycle. Its read data and error flag are due at the next falling clock edge, and the scoreboard compares them only where the bench has recorded a read strobe at the rising edge before. The transmit strobe is also due one edge after a data write, and its byte is popped from a queue. irq, rx_ready, bus_err and the control outputs are sampled one time unit after the edge that registers them. The same-cycle cases push the value from before the edge: a receive together with an identification read, and a receive together with a data read.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [IDX_W-1:0] {
    IDX_DATA  = 3'd0,
    IDX_IEN   = 3'd1,
    IDX_IID   = 3'd2,
    IDX_LCTL  = 3'd3,
    IDX_MCTL  = 3'd4,
    IDX_LSTAT = 3'd5,
    IDX_MSTAT = 3'd6,
    IDX_DIV   = 3'd7
  } reg_idx_e;

  typedef enum logic [2:0] {
    IID_LINE  = 3'h6,
    IID_RXD   = 3'h4,
    IID_THR   = 3'h2,
    IID_MODEM = 3'h0,
    IID_NONE  = 3'h1
  } iid_e;

  typedef struct packed {
    logic     rd_ok;
    logic     wr_ok;
    reg_idx_e idx;
    logic     bad;
  } access_t;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output access_t           acc
);
  localparam int unsigned WIN_LSB = 2 + IDX_W;

  logic     in_win;
  reg_idx_e idx;
  logic     rd_legal;
  logic     wr_legal;

  always_comb begin
    in_win = ((addr >> WIN_LSB) == '0);
    idx    = reg_idx_e'(addr[WIN_LSB-1:2]);
    unique case (idx)
      IDX_DATA:                       begin rd_legal = 1'b1; wr_legal = 1'b1; end
      IDX_IID, IDX_LSTAT, IDX_MSTAT:  begin rd_legal = 1'b1; wr_legal = 1'b0; end
      default:                        begin rd_legal = 1'b0; wr_legal = 1'b1; end
    endcase
    acc.idx   = idx;
    acc.rd_ok = rd & in_win & rd_legal;
    acc.wr_ok = wr & in_win & wr_legal;
    acc.bad   = (rd & ~(in_win & rd_legal)) | (wr & ~(in_win & wr_legal));
  end
endmodule

// File: rtl/uart_rf_line.sv
module uart_rf_line #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [2:0]        rx_err,
  input  logic              consume,
  input  logic [7:0]        modem_in,
  output logic [BYTE_W-1:0] rx_byte_q,
  output logic [7:0]        lstat_q,
  output logic [7:0]        lstat_d,
  output logic [7:0]        mstat_q,
  output logic [7:0]        mstat_d
);
  logic       dr_q, dr_d;
  logic       oe_q, oe_d;
  logic [2:0] flg_q, flg_d;

  always_comb begin
    dr_d  = rx_valid | (dr_q & ~consume);
    oe_d  = oe_q | (rx_valid & dr_q & ~consume);
    flg_d = rx_valid ? rx_err : flg_q;
    lstat_d = {1'b0, 1'b1, 1'b1, flg_d[2], flg_d[1], flg_d[0], oe_d, dr_d};
    lstat_q = {1'b0, 1'b1, 1'b1, flg_q[2], flg_q[1], flg_q[0], oe_q, dr_q};
    mstat_d = modem_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dr_q      <= 1'b0;
      oe_q      <= 1'b0;
      flg_q     <= '0;
      rx_byte_q <= '0;
      mstat_q   <= '0;
    end else begin
      dr_q    <= dr_d;
      oe_q    <= oe_d;
      flg_q   <= flg_d;
      mstat_q <= mstat_d;
      if (rx_valid) rx_byte_q <= rx_data;
    end
  end

  p_dr_set_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> lstat_q[0]);
  p_oe_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    lstat_q[1] |=> lstat_q[1]);
  p_consume_r5: assert property (@(posedge clk) disable iff (rst)
    (consume && !rx_valid) |=> !lstat_q[0]);
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] lstat_d,
  input  logic [7:0] mstat_d,
  input  logic [3:0] ien_d,
  output logic       irq_q,
  output iid_e       iid_q
);
  iid_e iid_d;

  always_comb begin
    if ((|lstat_d[4:1]) && ien_d[2])      iid_d = IID_LINE;
    else if (lstat_d[0] && ien_d[0])      iid_d = IID_RXD;
    else if (lstat_d[5] && ien_d[1])      iid_d = IID_THR;
    else if ((|mstat_d[3:0]) && ien_d[3]) iid_d = IID_MODEM;
    else                                  iid_d = IID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      iid_q <= IID_NONE;
    end else begin
      irq_q <= (iid_d != IID_NONE);
      iid_q <= iid_d;
    end
  end

  p_irq_code_r3: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !iid_q[0]);
  p_idle_code_r4: assert property (@(posedge clk) disable iff (rst)
    !irq_q |-> (iid_q == IID_NONE));
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_err,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [2:0]        rx_err,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic [7:0]        modem_status,
  output logic [REG_W-1:0]  lctl_o,
  output logic [REG_W-1:0]  mctl_o,
  output logic [REG_W-1:0]  div_o,
  output logic              irq
);
  localparam int unsigned NUM_CTL = 4;
  localparam reg_idx_e CTL_IDX [NUM_CTL] = '{IDX_IEN, IDX_LCTL, IDX_MCTL, IDX_DIV};

  access_t           acc;
  logic [BYTE_W-1:0] rx_byte_q;
  logic [7:0]        lstat_q, lstat_d, mstat_q, mstat_d;
  logic [REG_W-1:0]  ctl_q [NUM_CTL];
  logic [REG_W-1:0]  ctl_d [NUM_CTL];
  iid_e              iid_q;
  logic              irq_q;
  logic              consume;
  logic [REG_W-1:0]  rd_val;
  logic [REG_W-1:0]  rdata_q;
  logic              err_q;
  logic              txv_q;
  logic [BYTE_W-1:0] txd_q;

  uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .rd(bus_rd), .wr(bus_wr), .addr(bus_addr), .acc(acc)
  );

  assign consume = acc.rd_ok && (acc.idx == IDX_DATA);

  uart_rf_line #(.BYTE_W(BYTE_W)) u_line (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err(rx_err), .consume(consume), .modem_in(modem_status),
    .rx_byte_q(rx_byte_q), .lstat_q(lstat_q), .lstat_d(lstat_d),
    .mstat_q(mstat_q), .mstat_d(mstat_d)
  );

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    assign ctl_d[g] = (acc.wr_ok && (acc.idx == CTL_IDX[g])) ? bus_wdata : ctl_q[g];
    always_ff @(posedge clk) begin
      if (rst) ctl_q[g] <= '0;
      else     ctl_q[g] <= ctl_d[g];
    end
  end

  uart_rf_irq u_irq (
    .clk(clk), .rst(rst), .lstat_d(lstat_d), .mstat_d(mstat_d),
    .ien_d(ctl_d[0][3:0]), .irq_q(irq_q), .iid_q(iid_q)
  );

  always_comb begin
    rd_val = '0;
    if (acc.rd_ok && !acc.bad) begin
      unique case (acc.idx)
        IDX_DATA:  rd_val = REG_W'(rx_byte_q);
        IDX_IID:   rd_val = REG_W'(iid_q);
        IDX_LSTAT: rd_val = REG_W'(lstat_q);
        IDX_MSTAT: rd_val = REG_W'(mstat_q);
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      txv_q   <= 1'b0;
      txd_q   <= '0;
    end else begin
      rdata_q <= rd_val;
      err_q   <= acc.bad;
      txv_q   <= acc.wr_ok && (acc.idx == IDX_DATA);
      if (acc.wr_ok && (acc.idx == IDX_DATA)) txd_q <= bus_wdata[BYTE_W-1:0];
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign tx_valid  = txv_q;
  assign tx_data   = txd_q;
  assign rx_ready  = ~lstat_q[0];
  assign lctl_o    = ctl_q[1];
  assign mctl_o    = ctl_q[2];
  assign div_o     = ctl_q[3];
  assign irq       = irq_q;

  p_tx_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && !acc.bad && (acc.idx == IDX_DATA)) |=> tx_valid);
  p_err_rdata_r10: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == '0));
  p_ready_r11: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_ready);
endmodule

// File: tb/uart_regfile_tb_top.sv
module uart_regfile_tb_top;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_rd = 0, bus_wr = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [REG_W-1:0]  bus_wdata = '0;
  logic [REG_W-1:0]  bus_rdata;
  logic bus_err;
  logic rx_valid = 0;
  logic [BYTE_W-1:0] rx_data = '0;
  logic [2:0] rx_err = '0;
  logic rx_ready, tx_valid, irq;
  logic [BYTE_W-1:0] tx_data;
  logic [7:0] modem_status = '0;
  logic [REG_W-1:0] lctl_o, mctl_o, div_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [REG_W-1:0] exp_rd_q[$];
  logic             exp_err_q[$];
  string            rd_tag_q[$];
  logic [BYTE_W-1:0] exp_tx_q[$];
  logic rd_seen = 0;

  always #5 clk = ~clk;

  uart_regfile #(.ADDR_W(ADDR_W), .REG_W(REG_W), .BYTE_W(BYTE_W)) dut_i (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .modem_status(modem_status),
    .lctl_o(lctl_o), .mctl_o(mctl_o), .div_o(div_o), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: read data and error, due at the falling edge after the strobe edge
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_rd_q.size() == 0) begin
        chk(1'b0, "R2 unexpected read", bus_rdata, 0);
      end else begin
        logic [31:0] e;
        logic ee;
        string t;
        e  = exp_rd_q.pop_front();
        ee = exp_err_q.pop_front();
        t  = rd_tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
        chk(bus_err == ee, {t, " err"}, 32'(bus_err), 32'(ee));
      end
    end
    if (tx_valid && !rst) begin
      if (exp_tx_q.size() == 0) chk(1'b0, "R7 unexpected tx", 32'(tx_data), 0);
      else begin
        logic [7:0] et;
        et = exp_tx_q.pop_front();
        chk(tx_data == et, "R7 tx byte", 32'(tx_data), 32'(et));
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cyc(input bit rd, input bit wr, input int idx, input logic [31:0] wd,
                     input bit rxv, input logic [7:0] rxd, input logic [2:0] rxe);
    bus_rd = rd; bus_wr = wr; bus_addr = ADDR_W'(idx * 4); bus_wdata = wd;
    rx_valid = rxv; rx_data = rxd; rx_err = rxe;
    tick();
    bus_rd = 0; bus_wr = 0; rx_valid = 0; rx_err = '0;
  endtask

  task automatic rd_exp(input int idx, input logic [31:0] exp, input bit eerr, input string tag);
    exp_rd_q.push_back(exp); exp_err_q.push_back(eerr); rd_tag_q.push_back(tag);
    cyc(1, 0, idx, 0, 0, 0, 0);
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    cyc(0, 1, idx, d, 0, 0, 0);
  endtask

  task automatic rx(input logic [7:0] d, input logic [2:0] e);
    cyc(0, 0, 0, 0, 1, d, e);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) tick();
    rst = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    chk(rx_ready == 1, "R11 ready after reset", 32'(rx_ready), 1);
    chk(lctl_o == 0 && mctl_o == 0 && div_o == 0, "R1 ctl outputs", lctl_o | mctl_o | div_o, 0);
    rd_exp(5, 32'h60, 0, "R1 lstat");
    rd_exp(2, 32'h1, 0, "R1 iid");
    rd_exp(6, 32'h0, 0, "R1 mstat");

    // R3 holding-empty source
    wr(1, 32'h2);
    chk(irq == 1, "R3 thr irq", 32'(irq), 1);
    rd_exp(2, 32'h2, 0, "R3 thr code");
    // R4 nothing enabled active
    wr(1, 32'h1);
    chk(irq == 0, "R4 irq low", 32'(irq), 0);
    rd_exp(2, 32'h1, 0, "R4 none code");

    // R12 same-cycle read returns old code
    exp_rd_q.push_back(32'h1); exp_err_q.push_back(0); rd_tag_q.push_back("R12 old code");
    cyc(1, 0, 2, 0, 1, 8'hA5, 0);
    chk(irq == 1, "R12 irq at same edge", 32'(irq), 1);
    chk(rx_ready == 0, "R11 ready low", 32'(rx_ready), 0);
    rd_exp(2, 32'h4, 0, "R3 rxd code");
    // R5 read clears data ready
    rd_exp(0, 32'hA5, 0, "R5 data");
    chk(irq == 0, "R5 irq cleared", 32'(irq), 0);
    chk(rx_ready == 1, "R11 ready high", 32'(rx_ready), 1);
    rd_exp(5, 32'h60, 0, "R5 lstat");

    // R6 receive together with data read: no overrun
    rx(8'h33, 0);
    exp_rd_q.push_back(32'h33); exp_err_q.push_back(0); rd_tag_q.push_back("R6 simul old byte");
    cyc(1, 0, 0, 0, 1, 8'h44, 0);
    rd_exp(5, 32'h61, 0, "R6 no overrun");
    rd_exp(0, 32'h44, 0, "R6 new byte");

    // R13 error flags
    wr(1, 32'h4);
    rx(8'h55, 3'b101);
    rd_exp(5, 32'h75, 0, "R13 flags");
    chk(irq == 1, "R3 line irq", 32'(irq), 1);
    rd_exp(2, 32'h6, 0, "R3 line code");
    rd_exp(0, 32'h55, 0, "R5 data 2");
    rd_exp(5, 32'h74, 0, "R13 flags held");
    rx(8'h56, 3'b000);
    rd_exp(5, 32'h61, 0, "R13 flags reloaded");
    rd_exp(2, 32'h1, 0, "R4 none after flags");
    rd_exp(0, 32'h56, 0, "R5 data 3");

    // R3 modem source, R13 modem sampling
    wr(1, 32'h8);
    modem_status = 8'h01;
    tick();
    chk(irq == 1, "R3 modem irq", 32'(irq), 1);
    rd_exp(2, 32'h0, 0, "R3 modem code");
    rd_exp(6, 32'h01, 0, "R13 mstat");
    modem_status = 8'h10;
    tick();
    chk(irq == 0, "R4 modem high bits", 32'(irq), 0);
    rd_exp(2, 32'h1, 0, "R4 modem idle code");
    rd_exp(6, 32'h10, 0, "R13 mstat 2");
    modem_status = 8'h00;
    tick();

    // R3 priority: data ready over holding-empty
    wr(1, 32'h3);
    rx(8'h77, 0);
    rd_exp(2, 32'h4, 0, "R3 rxd over thr");
    rd_exp(0, 32'h77, 0, "R5 data 4");
    rd_exp(2, 32'h2, 0, "R3 thr after read");

    // R7 transmit does not disturb held byte
    rx(8'h88, 0);
    exp_tx_q.push_back(8'h5A);
    wr(0, 32'hAABBCC5A);
    rd_exp(0, 32'h88, 0, "R7 held byte");

    // R6 overrun, sticky
    wr(1, 32'h5);
    rx(8'h11, 0);
    rx(8'h22, 0);
    rd_exp(5, 32'h63, 0, "R6 overrun");
    rd_exp(2, 32'h6, 0, "R3 line over rxd");
    rd_exp(0, 32'h22, 0, "R6 replaced byte");
    rd_exp(5, 32'h62, 0, "R6 overrun sticky");
    chk(irq == 1, "R6 irq sticky", 32'(irq), 1);

    // R8 control words, R10 errors on reads of them
    wr(3, 32'hDEADBEEF);
    chk(lctl_o == 32'hDEADBEEF, "R8 lctl", lctl_o, 32'hDEADBEEF);
    chk(bus_err == 0, "R10 no err on legal write", 32'(bus_err), 0);
    wr(4, 32'h3);
    chk(mctl_o == 32'h3, "R8 mctl", mctl_o, 32'h3);
    wr(7, 32'h0001B207);
    chk(div_o == 32'h0001B207, "R8 div", div_o, 32'h0001B207);
    rd_exp(3, 32'h0, 1, "R8 lctl read zero");
    rd_exp(7, 32'h0, 1, "R8 div read zero");
    rd_exp(1, 32'h0, 1, "R8 ien read zero");
    wr(1, 32'h0000FF00);
    chk(irq == 0, "R8 ien low bits only", 32'(irq), 0);

    // R9 read-only writes ignored
    wr(5, 32'h0);
    chk(bus_err == 1, "R10 err on ro write", 32'(bus_err), 1);
    rd_exp(5, 32'h62, 0, "R9 lstat unchanged");
    wr(2, 32'hFF);
    wr(6, 32'hFF);
    rd_exp(6, 32'h00, 0, "R9 mstat unchanged");
    rd_exp(2, 32'h1, 0, "R9 iid unchanged");

    // R10 outside window
    rd_exp(8, 32'h0, 1, "R10 read outside");
    wr(63, 32'h12);
    chk(bus_err == 1, "R10 write outside", 32'(bus_err), 1);
    tick();
    chk(bus_err == 0, "R10 single pulse", 32'(bus_err), 0);

    // R1 reset clears overrun
    do_reset();
    rd_exp(5, 32'h60, 0, "R1 lstat after reset");
    tick(); tick();

    chk(exp_rd_q.size() == 0, "R2 reads drained", exp_rd_q.size(), 0);
    chk(exp_tx_q.size() == 0, "R7 tx drained", exp_tx_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule